// File: doc/BRIEF.md
# Two-of-Three Serial Pattern Detector

This block watches a one-bit serial stream, taking one bit on each rising clock edge. It raises a flag when exactly two of the three most recent bits are 1. The three bits are the bit on the input now and the two bits accepted before it. The flag is a Mealy output: it is computed from the stored history and the live input bit. It is therefore valid in the same cycle as the bit that completes the window. That bit enters the history on the next clock edge.

The history sits in a four-state machine, and a two-bit debug port shows the present state. The windows overlap: every edge slides the window by one bit and detection never restarts. A window with all three bits set does not fire. After reset the history is empty, and missing bits count as 0, so two 1s in a row after reset already raise the flag.

States and transitions (state code is {older bit, newest bit}):
- HIST_NONE (00): input 0 stays in HIST_NONE, input 1 moves to HIST_NEW.
- HIST_NEW (01): input 0 moves to HIST_OLD, input 1 moves to HIST_BOTH.
- HIST_OLD (10): input 0 moves to HIST_NONE, input 1 moves to HIST_NEW.
- HIST_BOTH (11): input 0 moves to HIST_OLD, input 1 stays in HIST_BOTH.

Top module: `tto_detector`

## Requirements
- R1: While the synchronous active-high reset is sampled high on a rising edge, the state becomes HIST_NONE (code 00). The flag is then 0 while the input is 0.
- R2: The flag is 1 exactly when the live input bit plus the two previously accepted bits sum to two.
- R3: A window of three 1s (state HIST_BOTH with input 1) gives a flag of 0.
- R4: The flag follows a change of the input within a cycle, with no clock edge in between (Mealy output).
- R5: Bits missing after reset count as 0: after reset, the input sequence 1,1 raises the flag on the second bit.
- R6: On every edge without reset, bit 0 of the state port takes the input bit and bit 1 takes the old bit 0. Windows overlap and detection never restarts.
- R7: A reset in the middle of a stream discards all history. After it, a single 1 does not raise the flag, and a second 1 does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit, one per cycle |
| detect_o | output | 1 | Exactly-two-of-three flag (Mealy) |
| state_o | output | 2 | Present state code {older, newest} |

## Verification
The patterns 011, 101 and 110 each check that the flag fires wherever the two 1s sit in the window. The pattern 111 separates a population count of two from a count of two or more. A stream of 1s right after reset checks that missing history counts as 0, and a reset in the middle of a stream shows whether old bits leak through. A long pseudo-random stream with overlapping windows is compared on every cycle against a queue-based model, and an input toggle within one cycle exposes a flag that has been registered by mistake.

// File: rtl/tto_pkg.sv
package tto_pkg;
    localparam int STATE_W = 2;

    // bit 1 = older history bit, bit 0 = newest history bit
    typedef enum logic [STATE_W-1:0] {
        HIST_NONE = 2'b00,
        HIST_NEW  = 2'b01,
        HIST_OLD  = 2'b10,
        HIST_BOTH = 2'b11
    } tto_state_e;

    localparam int HITS_NEEDED = 2;
endpackage

// File: rtl/tto_state_reg.sv
module tto_state_reg
    import tto_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  tto_state_e nxt_i,
    output tto_state_e cur_o
);
    always_ff @(posedge clk) begin
        if (rst) cur_o <= HIST_NONE;
        else     cur_o <= nxt_i;
    end

    // R6: newest bit moves to the older slot on each edge
    assert_shift_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cur_o[1] == $past(cur_o[0]));
endmodule

// File: rtl/tto_next_logic.sv
module tto_next_logic
    import tto_pkg::*;
(
    input  tto_state_e cur_i,
    input  logic       din,
    output tto_state_e nxt_o,
    output logic       hit_o
);
    always_comb begin
        nxt_o = HIST_NONE;
        unique case (cur_i)
            HIST_NONE: nxt_o = din ? HIST_NEW  : HIST_NONE;
            HIST_NEW:  nxt_o = din ? HIST_BOTH : HIST_OLD;
            HIST_OLD:  nxt_o = din ? HIST_NEW  : HIST_NONE;
            HIST_BOTH: nxt_o = din ? HIST_BOTH : HIST_OLD;
            default:   nxt_o = HIST_NONE;
        endcase
    end

    always_comb begin
        hit_o = 1'b0;
        unique case (cur_i)
            HIST_NONE: hit_o = 1'b0;
            HIST_NEW:  hit_o = din;
            HIST_OLD:  hit_o = din;
            HIST_BOTH: hit_o = ~din;
            default:   hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/tto_detector.sv
module tto_detector
    import tto_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               din,
    output logic               detect_o,
    output logic [STATE_W-1:0] state_o
);
    tto_state_e cur_s;
    tto_state_e nxt_s;
    logic       hit_s;

    tto_state_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .nxt_i (nxt_s),
        .cur_o (cur_s)
    );

    tto_next_logic u_logic (
        .cur_i (cur_s),
        .din   (din),
        .nxt_o (nxt_s),
        .hit_o (hit_s)
    );

    assign detect_o = hit_s;
    assign state_o  = cur_s;

    // R1: a sampled reset empties the history
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> state_o == 2'b00);

    // R3: three ones in the window never fire
    assert_no_three_R3: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b11 && din) |-> !detect_o);

    // R2: the flag matches the population count of the window
    assert_count_two_R2: assert property (@(posedge clk) disable iff (rst)
        detect_o == ($countones({state_o, din}) == HITS_NEEDED));

    // R6: the live bit becomes the newest history bit
    assert_take_bit_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> state_o[0] == $past(din));
endmodule

// File: tb/tto_detector_tb_top.sv
module tto_detector_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic       detect_o;
    logic [1:0] state_o;

    int checks = 0;
    int errors = 0;
    int hist[$];
    bit done = 0;

    always #10 clk = ~clk;

    tto_detector dut_i (
        .clk      (clk),
        .rst      (rst),
        .din      (din),
        .detect_o (detect_o),
        .state_o  (state_o)
    );

    function automatic int past_bit(int back);
        if (hist.size() >= back) return hist[hist.size() - back];
        return 0;
    endfunction

    function automatic logic exp_flag(logic b);
        return (past_bit(1) + past_bit(2) + int'(b)) == 2;
    endfunction

    task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // drive one bit in the low phase, check the flag and state, then let the edge take it
    task automatic step(logic b, string tag);
        @(negedge clk);
        din = b;
        #5;
        check({tag, " detect"}, {1'b0, detect_o}, {1'b0, exp_flag(b)});
        check({tag, " state"}, state_o, {past_bit(2) == 1, past_bit(1) == 1});
        hist.push_back(int'(b));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        din = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        hist.delete();
        #5;
        check("R1 reset state", state_o, 2'b00);
        check("R1 reset flag", {1'b0, detect_o}, 2'b00);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr = 32'hACE1_2468;
        repeat (2) @(posedge clk);
        do_reset();

        // R5: two leading ones fire on the second bit
        step(1'b1, "R5 first");
        step(1'b1, "R5 second");
        step(1'b1, "R3 three ones");
        step(1'b1, "R3 still three");

        // R4: flag follows din inside one cycle (history now 1,1)
        @(negedge clk);
        din = 1'b1;
        #3;
        check("R4 din high", {1'b0, detect_o}, 2'b00);
        din = 1'b0;
        #3;
        check("R4 din low", {1'b0, detect_o}, 2'b01);
        hist.push_back(0);

        do_reset();
        // directed patterns 011, 101, 110 (R2) and overlap (R6)
        step(1'b0, "R2 p011 a"); step(1'b1, "R2 p011 b"); step(1'b1, "R2 p011 c");
        step(1'b0, "R6 p110 end"); step(1'b1, "R2 p101 c");
        step(1'b0, "R6 gap"); step(1'b0, "R6 gap2");
        step(1'b1, "R2 p110 a"); step(1'b1, "R2 p110 b"); step(1'b0, "R2 p110 c");

        // R7: reset mid-stream drops history
        step(1'b1, "R7 pre");
        do_reset();
        step(1'b1, "R7 single one");
        step(1'b1, "R7 second one");

        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[0], "R2 random");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule